// File: doc/BRIEF.md
# Prescaler-Tapped Watchdog Timer

This block guards a processor against runaway software. Two free-running prescalers act as shared timebases. The main prescaler advances on every clock. The watch prescaler advances only on cycles where a slow sub-clock enable is high. Each prescaler produces a carry pulse at four tap points. A 2-bit watchdog counter counts the carry pulses from one tap. The tap is chosen by an interval select and by a source select. When the counter wraps past its top value, the block emits a one-cycle reset pulse for the CPU.

Software arms the block once with `arm`. From then on it must pulse `kick` often enough. The only way out of the armed state is the reset pulse itself. A tap carry arrives at any phase relative to a kick, so the timeout is not exact. It lies between three and four tap periods after the last kick or after arming. Clearing the main prescaler through `pre_clr` holds back its carries and so stretches that window. With the default taps, the main-source windows centre near 2^14, 2^16, 2^18 and 2^21 clock cycles. The sub-source windows centre near 2^12, 2^15, 2^16 and 2^17 sub-clock ticks.

Top module: `wdt_tapped`

## Requirements
- R1: After reset, `rst_pulse` is 0 and `armed` is 0.
- R2: An `arm` pulse while disarmed sets `armed` on the next cycle, captures `ival_sel` and `src_main`, and zeroes the 2-bit counter. The first `rst_pulse` then appears between 3P+1 and 4P source ticks after the arming edge, where P is the tap period of the captured setting.
- R3: With `src_main` = 1, the main prescaler is the source and a tick is every clock cycle. The period P is 2^MAIN_TAPS byte[sel]. Byte 0 (bits 7:0) serves `ival_sel` = 0, and byte 3 serves `ival_sel` = 3.
- R4: With `src_main` = 0, the watch prescaler is the source and a tick is a cycle with `sub_tick` = 1. The period P is 2^SUB_TAPS byte[sel], with the same byte order as R3.
- R5: A `kick` while armed zeroes the counter. A kick in the same cycle as a tap carry wins over the carry. Kicks spaced closer than 3P+1 ticks keep `rst_pulse` at 0 indefinitely. After the last kick, the pulse lands 3P+1 to 4P ticks later.
- R6: `rst_pulse` is high for exactly one cycle. In that same cycle `armed` reads 0.
- R7: `armed` falls only together with `rst_pulse`. An `arm` pulse, a new `ival_sel` or a new `src_main` while armed has no effect on the timing.
- R8: A `kick` while disarmed has no effect: `armed` stays 0 and no pulse occurs.
- R9: `pre_clr` = 1 holds the main prescaler at zero, so no main carry occurs. After release, the main-source carries fall exactly at multiples of P clock cycles. From a zeroed counter, the pulse therefore comes exactly 4P cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | Sub-clock enable for the watch prescaler |
| pre_clr | input | 1 | Clears and holds the main prescaler |
| arm | input | 1 | Start strobe |
| kick | input | 1 | Counter clear strobe |
| ival_sel | input | 2 | Interval (tap) select, sampled at arming |
| src_main | input | 1 | 1: main prescaler, 0: watch prescaler; sampled at arming |
| rst_pulse | output | 1 | One-cycle CPU reset request |
| armed | output | 1 | Watchdog is running |

## Verification
Every pairing of source and interval select is driven twice. In the first pass the timeout is measured from arming. In the second pass it is measured from a kick issued a few cycles later. Each measured tick count must fall inside its own 3P+1..4P window. That separates a wrong tap, a wrong source mux and a counter that wraps one step early or late.

Several directed patterns follow:
- Steady kicking tells a kick that clears from one that is ignored.
- A second arm with a different setting shows whether the configuration is relatched.
- Holding `pre_clr` fixes the prescaler phase, so exact timings can be checked. This exposes a missing prescaler clear.
- A kick placed on the very cycle of a carry exposes wrong priority between the two.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned N_TAPS = 4;
  localparam int unsigned TAP_BW = 8;

  function automatic int unsigned max_tap(input logic [N_TAPS*TAP_BW-1:0] taps);
    int unsigned m;
    m = 1;
    for (int i = 0; i < N_TAPS; i++)
      if (int'(taps[i*TAP_BW +: TAP_BW]) > m) m = int'(taps[i*TAP_BW +: TAP_BW]);
    return m;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter logic [31:0] TAPS = 32'h13_10_0E_0C,
  localparam int unsigned W = wdt_pkg::max_tap(TAPS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       clr,
  output logic [3:0] carry
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_tap
    localparam int unsigned L = int'(TAPS[i*8 +: 8]);
    assign carry[i] = tick && !clr && (&cnt_q[L-1:0]);
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int unsigned CNT_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       kick,
  input  logic [1:0] ival_sel,
  input  logic       src_main,
  input  logic [3:0] main_carry,
  input  logic [3:0] sub_carry,
  output logic       rst_pulse,
  output logic       armed
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       sel_q;
  logic             src_q, armed_q, pulse_q;
  logic             tap_c;

  assign tap_c = src_q ? main_carry[sel_q] : sub_carry[sel_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sel_q   <= '0;
      src_q   <= 1'b0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (!armed_q) begin
        if (arm) begin
          armed_q <= 1'b1;
          sel_q   <= ival_sel;
          src_q   <= src_main;
          cnt_q   <= '0;
        end
      end else if (kick) begin
        cnt_q <= '0;
      end else if (tap_c) begin
        if (cnt_q == TOP) begin
          pulse_q <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rst_pulse = pulse_q;
  assign armed     = armed_q;
endmodule

// File: rtl/wdt_tapped.sv
module wdt_tapped #(
  parameter logic [31:0] MAIN_TAPS = 32'h13_10_0E_0C,
  parameter logic [31:0] SUB_TAPS  = 32'h0F_0E_0D_0A,
  parameter int unsigned CNT_W     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       pre_clr,
  input  logic       arm,
  input  logic       kick,
  input  logic [1:0] ival_sel,
  input  logic       src_main,
  output logic       rst_pulse,
  output logic       armed
);
  logic [3:0] main_carry, sub_carry;

  wdt_prescaler #(.TAPS(MAIN_TAPS)) u_main_pre (
    .clk(clk), .rst_n(rst_n), .tick(1'b1), .clr(pre_clr), .carry(main_carry)
  );

  wdt_prescaler #(.TAPS(SUB_TAPS)) u_sub_pre (
    .clk(clk), .rst_n(rst_n), .tick(sub_tick), .clr(1'b0), .carry(sub_carry)
  );

  wdt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .arm(arm), .kick(kick),
    .ival_sel(ival_sel), .src_main(src_main),
    .main_carry(main_carry), .sub_carry(sub_carry),
    .rst_pulse(rst_pulse), .armed(armed)
  );
endmodule

// File: rtl/wdt_tapped_chk.sv
module wdt_tapped_chk (
  input logic clk,
  input logic rst_n,
  input logic arm,
  input logic kick,
  input logic rst_pulse,
  input logic armed
);
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
  p_idle_with_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> !armed);
  p_pulse_needs_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(armed));
  p_arm_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !armed) |=> armed);
  p_kick_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && armed) |=> !rst_pulse);
  p_stop_only_by_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> rst_pulse);
  p_idle_kick_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !arm) |=> !armed && !rst_pulse);
endmodule

bind wdt_tapped wdt_tapped_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .kick(kick),
  .rst_pulse(rst_pulse), .armed(armed)
);

// File: tb/tb_wdt_tapped.sv
module tb_wdt_tapped;
  localparam logic [31:0] MT = 32'h06_05_04_03;
  localparam logic [31:0] ST = 32'h05_04_03_02;

  logic clk = 1'b0, rst_n = 1'b0, sub_tick = 1'b0, pre_clr = 1'b0;
  logic arm = 1'b0, kick = 1'b0, src_main = 1'b0;
  logic [1:0] ival_sel = 2'd0;
  logic rst_pulse, armed;

  int checks = 0, errors = 0;
  int cyc = 0, subc = 0, ph = 0;

  always #4 clk = ~clk;

  wdt_tapped #(.MAIN_TAPS(MT), .SUB_TAPS(ST)) dut (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .pre_clr(pre_clr),
    .arm(arm), .kick(kick), .ival_sel(ival_sel), .src_main(src_main),
    .rst_pulse(rst_pulse), .armed(armed)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sub_tick) subc <= subc + 1;
  end

  always @(negedge clk) begin
    ph       <= (ph == 2) ? 0 : ph + 1;
    sub_tick <= (ph == 0);
  end

  // Each entry: {src_main, ival_sel[1:0], kick delay[4:0]}
  localparam logic [7:0] VEC [16] = '{
    {1'b1, 2'd0, 5'd0}, {1'b1, 2'd1, 5'd0}, {1'b1, 2'd2, 5'd0}, {1'b1, 2'd3, 5'd0},
    {1'b0, 2'd0, 5'd0}, {1'b0, 2'd1, 5'd0}, {1'b0, 2'd2, 5'd0}, {1'b0, 2'd3, 5'd0},
    {1'b1, 2'd0, 5'd6}, {1'b1, 2'd1, 5'd9}, {1'b1, 2'd2, 5'd3}, {1'b1, 2'd3, 5'd17},
    {1'b0, 2'd0, 5'd4}, {1'b0, 2'd1, 5'd8}, {1'b0, 2'd2, 5'd13}, {1'b0, 2'd3, 5'd20}
  };

  function automatic int period(input logic s, input logic [1:0] sel);
    return 1 << (s ? int'(MT[sel*8 +: 8]) : int'(ST[sel*8 +: 8]));
  endfunction

  function automatic int ticks(input logic s);
    return s ? cyc : subc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for the pulse; returns the tick count since snap, or -1 if none came.
  task automatic wait_pulse(input logic s, input int snap, input int limit, output int n);
    n = -1;
    for (int k = 0; k < limit; k++) begin
      if (rst_pulse) begin
        n = ticks(s) - snap;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_pulse_tail(input string req);
    chk(armed == 1'b0, req, armed, 0);
    @(negedge clk);
    chk(rst_pulse == 1'b0, req, rst_pulse, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, snap, p;
    repeat (4) @(negedge clk);
    chk(rst_pulse == 1'b0, "R1 pulse in reset", rst_pulse, 0);
    chk(armed == 1'b0, "R1 armed in reset", armed, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(armed == 1'b0 && rst_pulse == 1'b0, "R1 after reset", armed, 0);

    // Table walk: R2 (from arming), R5 (from a kick), R3 main taps, R4 sub taps
    for (int i = 0; i < 16; i++) begin
      logic s; logic [1:0] sel; int d;
      s = VEC[i][7]; sel = VEC[i][6:5]; d = int'(VEC[i][4:0]);
      p = period(s, sel);
      arm = 1'b1; src_main = s; ival_sel = sel;
      @(negedge clk);
      arm = 1'b0;
      snap = ticks(s);
      chk(armed == 1'b1, "R2 armed after arm", armed, 1);
      if (d > 0) begin
        repeat (d) @(negedge clk);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        snap = ticks(s);
      end
      wait_pulse(s, snap, 20000, n);
      chk(n >= 3 * p + 1 && n <= 4 * p,
          s ? (d > 0 ? "R5 R3 window after kick" : "R2 R3 window after arm")
            : (d > 0 ? "R5 R4 window after kick" : "R2 R4 window after arm"),
          n, 4 * p);
      check_pulse_tail("R6 single pulse, disarmed");
      repeat (3) @(negedge clk);
    end

    // R5: steady kicking keeps the pulse away
    p = period(1'b1, 2'd0);
    arm = 1'b1; src_main = 1'b1; ival_sel = 2'd0;
    @(negedge clk);
    arm = 1'b0;
    n = 0;
    for (int k = 0; k < 15; k++) begin
      for (int j = 0; j < 20; j++) begin
        if (rst_pulse) n++;
        @(negedge clk);
      end
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    snap = cyc;
    chk(n == 0, "R5 kicks suppress pulse", n, 0);
    chk(armed == 1'b1, "R5 still armed", armed, 1);
    wait_pulse(1'b1, snap, 2000, n);
    chk(n >= 3 * p + 1 && n <= 4 * p, "R5 window after last kick", n, 4 * p);
    check_pulse_tail("R6 tail after kicks");

    // R7: re-arm with other settings while armed is ignored
    arm = 1'b1; src_main = 1'b1; ival_sel = 2'd0;
    @(negedge clk);
    arm = 1'b0;
    snap = cyc;
    repeat (2) @(negedge clk);
    arm = 1'b1; src_main = 1'b0; ival_sel = 2'd3;
    @(negedge clk);
    arm = 1'b0;
    wait_pulse(1'b1, snap, 2000, n);
    chk(n >= 3 * p + 1 && n <= 4 * p, "R7 second arm ignored", n, 4 * p);
    check_pulse_tail("R7 tail");

    // R8: a kick while disarmed does nothing
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      if (rst_pulse || armed) n++;
      @(negedge clk);
    end
    chk(n == 0, "R8 idle kick no effect", n, 0);

    // R9: prescaler clear stretches the timeout; exact timing once released
    arm = 1'b1; src_main = 1'b1; ival_sel = 2'd0; pre_clr = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    snap = cyc;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      if (rst_pulse) n++;
      @(negedge clk);
    end
    chk(n == 0 && armed == 1'b1, "R9 held prescaler gives no pulse", n, 0);
    pre_clr = 1'b0;
    snap = cyc;
    wait_pulse(1'b1, snap, 2000, n);
    chk(n == 4 * p, "R9 exact 4P after release", n, 4 * p);
    check_pulse_tail("R9 tail");

    // R5: a kick coinciding with the fourth carry wins
    arm = 1'b1; src_main = 1'b1; ival_sel = 2'd0; pre_clr = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (10) @(negedge clk);
    pre_clr = 1'b0;
    snap = cyc;
    repeat (4 * p - 1) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    chk(rst_pulse == 1'b0, "R5 kick beats coincident carry", rst_pulse, 0);
    wait_pulse(1'b1, snap, 2000, n);
    chk(n == 8 * p, "R5 restart after coincident kick", n, 8 * p);
    check_pulse_tail("R6 tail after coincident kick");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule